// File: doc/BRIEF.md
# Keyboard Scan-Code Wake Detector

This block listens to the clock and data lines of a PS/2-style keyboard. It rebuilds each serial frame from the keyboard and compares the received byte with one scan code that software has programmed. Only frames that pass every framing and parity check are compared. A match sets a wake status flag that stays set until software clears it. When the matching enable flag is also set, the block raises a wake request toward the power-management logic.

Both keyboard lines pass through a synchroniser clocked by the slow sampling clock. A data bit is taken on each falling edge of the keyboard clock. If the line stays quiet for too long, the partial frame is dropped so that the next start bit lines up again.

A small register port holds four registers:
- the scan code,
- the status flag,
- the enable flag,
- an off switch that is active-high and resets to 0, so the detector is running after reset.

Top module: `kbd_wake_det`

## Requirements
- R1: After the synchronous reset, every register reads 0 and `wake_req` is 0. The registers are: code at address 0, status at address 1, enable at address 2, control at address 3.
- R2: A frame is 11 bits, sampled on falling edges of `kb_clk`, in this order: start, data bit 0 first through data bit 7, parity, stop. A valid frame whose byte equals the code register sets status bit 5.
- R3: A valid frame whose byte differs from the code leaves status bit 5 unchanged. This includes the bit-reversed form of the code.
- R4: A frame in which the data bits plus the parity bit hold an even number of ones is discarded. The status does not change.
- R5: A frame whose start bit is 1 is discarded.
- R6: A frame whose stop bit is 0 is discarded.
- R7: Status bit 5 is sticky. Writing 1 to bit 5 at address 1 clears it, and writing 0 there has no effect.
- R8: `wake_req` is 1 only while status bit 5 and enable bit 5 (address 2) are both 1. It follows them one cycle later.
- R9: While control bit 0 (address 3) is 1, the detector ignores all keyboard activity. When that bit is 0 again, the detector works.
- R10: If no falling edge of `kb_clk` arrives for `IDLE_CYC` sampling cycles, any partial frame is dropped. The next edge is then taken as a start bit.
- R11: The code register reads back all 8 bits written. The enable register reads back only bit 5, and the control register reads back only bit 0. Read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (the slow always-on clock) |
| rst | input | 1 | Synchronous active-high standby-power reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| kb_clk | input | 1 | Keyboard clock line (asynchronous) |
| kb_dat | input | 1 | Keyboard data line (asynchronous) |
| wake_req | output | 1 | Wake request, active high |

## Verification
The code used is 0x1C, which is not symmetric under bit reversal. Sending its mirror image, 0x38, catches a design that shifts the byte in most significant bit first: such a design would wake on the wrong key. Three corrupted frames carry the right byte but have a bad parity, start or stop bit. A design that skipped any one of those checks would set status on them. Further tests cover:
- a partial frame followed by a long gap, which misaligns every later frame in a design without the idle timeout;
- a write of 0 to the status register, which a design with a plain clear would treat as a clear;
- frames sent while the off bit is set, which a design that ignored the bit would still match.

// File: rtl/kbw_pkg.sv
package kbw_pkg;
  typedef enum logic [1:0] {
    A_CODE = 2'd0,
    A_STS  = 2'd1,
    A_EN   = 2'd2,
    A_CTL  = 2'd3
  } kbw_addr_e;

  localparam int unsigned WAKE_BIT = 5;
  localparam int unsigned OFF_BIT  = 0;
endpackage

// File: rtl/kbw_sync.sv
module kbw_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= din;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/kbw_frame.sv
module kbw_frame #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned IDLE_CYC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              off,
  input  logic              kc_s,
  input  logic              kd_s,
  output logic              frame_ok,
  output logic [DATA_W-1:0] frame_byte
);
  localparam int unsigned FB   = DATA_W + 3;
  localparam int unsigned CW   = $clog2(FB);
  localparam int unsigned IW   = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FB - 1);
  localparam logic [IW-1:0] IDLE = IW'(IDLE_CYC);

  logic          run_rst;
  logic          kc_q;
  logic          fall;
  logic [CW-1:0] bit_cnt;
  logic [IW-1:0] idle_q;
  logic [FB-2:0] sh;
  logic [FB-1:0] full;
  logic          good;

  assign run_rst = rst | off;
  assign fall    = kc_q & ~kc_s;
  assign full    = {kd_s, sh};
  // start low, stop high, odd ones over data plus parity
  assign good    = ~full[0] & full[FB-1] & (^full[FB-2:1]);

  always_ff @(posedge clk) begin
    if (run_rst) begin
      kc_q       <= 1'b1;
      bit_cnt    <= '0;
      idle_q     <= '0;
      sh         <= '0;
      frame_ok   <= 1'b0;
      frame_byte <= '0;
    end else begin
      kc_q     <= kc_s;
      frame_ok <= 1'b0;
      if (fall) begin
        idle_q <= '0;
        sh     <= full[FB-1:1];
        if (bit_cnt == LAST) begin
          bit_cnt <= '0;
          if (good) begin
            frame_ok   <= 1'b1;
            frame_byte <= full[DATA_W:1];
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else begin
        if (idle_q != IDLE) idle_q <= idle_q + 1'b1;
        if (idle_q == IDLE) bit_cnt <= '0;
      end
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= LAST);

  p_timeout_r10: assert property (@(posedge clk) disable iff (run_rst)
    (idle_q == IDLE) && !fall |=> bit_cnt == '0);

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $past(off) |-> !frame_ok);
endmodule

// File: rtl/kbw_regs.sv
module kbw_regs
  import kbw_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_ok,
  input  logic [DATA_W-1:0] frame_byte,
  output logic              off,
  output logic [DATA_W-1:0] rdata,
  output logic              wake
);
  logic [DATA_W-1:0] code_q;
  logic              sts_q;
  logic              en_q;
  logic              off_q;
  logic              hit;
  logic              clr;

  assign hit = frame_ok && (frame_byte == code_q);
  assign clr = we && (addr == A_STS) && wdata[WAKE_BIT];
  assign off = off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      sts_q  <= 1'b0;
      en_q   <= 1'b0;
      off_q  <= 1'b0;
      wake   <= 1'b0;
      rdata  <= '0;
    end else begin
      if (we && addr == A_CODE) code_q <= wdata;
      if (we && addr == A_EN)   en_q   <= wdata[WAKE_BIT];
      if (we && addr == A_CTL)  off_q  <= wdata[OFF_BIT];
      if (hit)      sts_q <= 1'b1;
      else if (clr) sts_q <= 1'b0;
      wake <= sts_q & en_q;
      rdata <= '0;
      case (addr)
        A_CODE:  rdata <= code_q;
        A_STS:   rdata[WAKE_BIT] <= sts_q;
        A_EN:    rdata[WAKE_BIT] <= en_q;
        default: rdata[OFF_BIT] <= off_q;
      endcase
    end
  end

  p_match_sets_r2: assert property (@(posedge clk) disable iff (rst)
    frame_ok && frame_byte == code_q |=> sts_q);

  p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
    !sts_q && !(frame_ok && frame_byte == code_q) |=> !sts_q);

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    sts_q && !(we && addr == A_STS && wdata[WAKE_BIT]) |=> sts_q);

  p_wake_gate_r8: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(en_q) && $past(sts_q));
endmodule

// File: rtl/kbd_wake_det.sv
module kbd_wake_det #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SYNC_N   = 2,
  parameter int unsigned IDLE_CYC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              kb_clk,
  input  logic              kb_dat,
  output logic              wake_req
);
  logic [1:0]        line_s;
  logic              off;
  logic              frame_ok;
  logic [DATA_W-1:0] frame_byte;

  kbw_sync #(.W(2), .STAGES(SYNC_N), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({kb_clk, kb_dat}),
    .dout(line_s)
  );

  kbw_frame #(.DATA_W(DATA_W), .IDLE_CYC(IDLE_CYC)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .off       (off),
    .kc_s      (line_s[1]),
    .kd_s      (line_s[0]),
    .frame_ok  (frame_ok),
    .frame_byte(frame_byte)
  );

  kbw_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .frame_ok  (frame_ok),
    .frame_byte(frame_byte),
    .off       (off),
    .rdata     (reg_rdata),
    .wake      (wake_req)
  );
endmodule

// File: tb/kbd_wake_det_tb_top.sv
`timescale 1ns/1ps
module kbd_wake_det_tb_top;
  localparam int HALF = 8;
  localparam int IDLE = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       kb_clk = 1'b1;
  logic       kb_dat = 1'b1;
  logic       wake_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit exp_q[$];

  always #5 clk = ~clk;

  kbd_wake_det #(.IDLE_CYC(IDLE)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .kb_clk(kb_clk), .kb_dat(kb_dat), .wake_req(wake_req)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic send_bit(logic b);
    kb_dat = b;
    repeat (HALF) @(negedge clk);
    kb_clk = 1'b0;
    repeat (HALF) @(negedge clk);
    kb_clk = 1'b1;
  endtask

  // driver: sends a frame and queues the expected status bit
  task automatic drive_frame(logic [7:0] b, bit bad_start, bit bad_par,
                             bit bad_stop, bit exp_sts);
    logic par;
    par = ~^b;
    if (bad_par) par = ~par;
    send_bit(bad_start);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit(par);
    send_bit(~bad_stop);
    repeat (IDLE + 20) @(negedge clk);
    exp_q.push_back(exp_sts);
  endtask

  // monitor: reads status and compares with the oldest queued item
  task automatic monitor(string tag);
    logic [7:0] d;
    bit e;
    rd(2'd1, d);
    e = exp_q.pop_front();
    chk(tag, {7'd0, d[5]}, {7'd0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(2'd0, d); chk("R1 code", d, 8'h00);
    rd(2'd1, d); chk("R1 sts",  d, 8'h00);
    rd(2'd2, d); chk("R1 en",   d, 8'h00);
    rd(2'd3, d); chk("R1 ctl",  d, 8'h00);
    chk("R1 wake", {7'd0, wake_req}, 8'h00);
    // R11 readback
    wr(2'd0, 8'h1C); rd(2'd0, d); chk("R11 code", d, 8'h1C);
    wr(2'd2, 8'hFF); rd(2'd2, d); chk("R11 en", d, 8'h20);
    wr(2'd3, 8'hFE); rd(2'd3, d); chk("R11 ctl", d, 8'h00);
    wr(2'd2, 8'h00);
    // R2 match, R8 no wake while disabled
    drive_frame(8'h1C, 0, 0, 0, 1); monitor("R2 match");
    chk("R8 wake off", {7'd0, wake_req}, 8'h00);
    // R7 write 0 ignored, write 1 clears
    wr(2'd1, 8'hDF); rd(2'd1, d); chk("R7 w0 keeps", d, 8'h20);
    wr(2'd1, 8'h20); rd(2'd1, d); chk("R7 w1 clears", d, 8'h00);
    // R3 mismatch and reversed byte
    drive_frame(8'h38, 0, 0, 0, 0); monitor("R3 reversed");
    drive_frame(8'h1D, 0, 0, 0, 0); monitor("R3 other");
    // R4 R5 R6 discards
    drive_frame(8'h1C, 0, 1, 0, 0); monitor("R4 parity");
    drive_frame(8'h1C, 1, 0, 0, 0); monitor("R5 start");
    drive_frame(8'h1C, 0, 0, 1, 0); monitor("R6 stop");
    // R7 sticky across a mismatch
    drive_frame(8'h1C, 0, 0, 0, 1); monitor("R7 set");
    drive_frame(8'h55, 0, 0, 0, 1); monitor("R7 sticky");
    // R8 wake with enable
    wr(2'd2, 8'h20);
    repeat (3) @(negedge clk);
    chk("R8 wake on", {7'd0, wake_req}, 8'h01);
    wr(2'd1, 8'h20);
    repeat (3) @(negedge clk);
    chk("R8 wake drops", {7'd0, wake_req}, 8'h00);
    // R9 off bit
    wr(2'd3, 8'h01); rd(2'd3, d); chk("R9 ctl", d, 8'h01);
    drive_frame(8'h1C, 0, 0, 0, 0); monitor("R9 off ignores");
    chk("R9 wake", {7'd0, wake_req}, 8'h00);
    wr(2'd3, 8'h00);
    drive_frame(8'h1C, 0, 0, 0, 1); monitor("R9 back on");
    wr(2'd1, 8'h20);
    // R10 idle timeout drops partial frame
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    repeat (IDLE + 40) @(negedge clk);
    drive_frame(8'h1C, 0, 0, 0, 1); monitor("R10 realign");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule